// File: doc/BRIEF.md
# Masked Block-Write Datapath

This block works out what a video memory row should receive on a write. Each cycle it takes one function code along with four values: the data bus value held when the row was opened, the data bus value at column time, a column address and the active byte-lane strobes. One clock later it presents a group of eight consecutive columns, which are a base column plus eight slots. For each slot it gives write data and a per-bit enable. The array itself and any strobe timing belong to the surrounding logic, which simply writes the enabled bits.

The block can perform a word write to one column. It can also perform a block write, which copies a stored color value into any of the eight columns. In a block write, a column mask taken from the column-time data bus picks which columns and which bytes receive the color. A separate per-bit I/O mask narrows every write further. That mask comes either from the row-time bus or from a stored mask register. Loading the mask register switches the block into a persistent mode in which the stored mask is the source, and a dedicated function code ends that mode.

Top module: `blkwr_datapath`

## Requirements
- R1: While reset is high and in the first cycle after it, `wr_valid` is 0 and `wr_bit_en` and `wr_data` are all zero. Persistent mode is off after reset.
- R2: The function codes are as follows: 0 idle, 1 word write, 2 masked word write, 3 block write, 4 masked block write, 5 load mask register, 6 load color register, 7 end persistent mode. A code accepted with `op_valid` high produces its outputs one clock later. Codes 1 to 4 raise `wr_valid`. Every other code, and any cycle with `op_valid` low, gives `wr_valid` 0 with all enables and data zero.
- R3: A word write targets slot `col_addr[2:0]` in the group whose base is `col_addr` with bits 2:0 cleared. That slot carries `col_dq`, and all other slots carry zero data and zero enables.
- R4: A masked write (codes 2 and 4) outside persistent mode uses `row_dq` as the I/O mask. A 1 bit enables that data bit.
- R5: Code 5 stores `col_dq` in the mask register and turns persistent mode on. While the mode is on, masked writes use the mask register, and `row_dq` has no effect on the enables.
- R6: Code 7 turns persistent mode off, so masked writes use `row_dq` again. Persistent mode changes only through codes 5 and 7 and reset.
- R7: Code 6 stores `col_dq` as the color. Every slot of a block write carries the color, and the color changes only through code 6.
- R8: A block write ignores `col_addr[2:0]`. Its base is `col_addr[8:3]` followed by three zero bits.
- R9: In a block write, bit b of slot i is enabled when all three of the following are 1. The first is the column-mask bit, which is `col_dq[i]` for bits 7:0 and `col_dq[8+i]` for bits 15:8. The second is I/O mask bit b. The third is `lane_en[0]` for the low byte or `lane_en[1]` for the high byte. A word write applies the I/O mask and the lane strobes in the same way.
- R10: Unmasked writes (codes 1 and 3) use an all-ones I/O mask, whether or not persistent mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | The function code is valid this cycle |
| op_code | input | 3 | Function code (see R2) |
| row_dq | input | 16 | Data bus value captured at row open |
| col_dq | input | 16 | Data bus value at column time |
| col_addr | input | 9 | Column address |
| lane_en | input | 2 | Byte-lane strobes, bit 0 low byte, bit 1 high byte |
| wr_valid | output | 1 | A write group is presented |
| wr_col_base | output | 9 | First column of the group, always a multiple of 8 |
| wr_data | output | 128 | Write data, slot i in bits 16i+15:16i |
| wr_bit_en | output | 128 | Per-bit write enables, laid out as `wr_data` |

## Verification
The assertions assume that `op_code` is a defined three-bit value whenever `op_valid` is high. They also assume that only one function is issued per clock, so a color or mask load never shares a cycle with the write that reads the loaded value. The stimulus changes inputs only on the falling edge and issues one code per cycle, drawn from all eight values with random addresses, buses and lane strobes. Directed sequences place loads directly before writes, and place the end of persistent mode directly before masked writes, so that these orderings are tested.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE        = 3'd0,
    OP_WORD        = 3'd1,
    OP_WORD_MSK    = 3'd2,
    OP_BLOCK       = 3'd3,
    OP_BLOCK_MSK   = 3'd4,
    OP_LD_MASK     = 3'd5,
    OP_LD_COLOR    = 3'd6,
    OP_END_PERSIST = 3'd7
  } op_e;
endpackage

// File: rtl/bwr_regs.sv
module bwr_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mask,
  input  logic              ld_color,
  input  logic              end_persist,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              persist_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      color_q   <= '0;
      mask_q    <= '0;
      persist_q <= 1'b0;
    end else begin
      if (ld_color) color_q <= din;
      if (ld_mask) begin
        mask_q    <= din;
        persist_q <= 1'b1;
      end else if (end_persist) begin
        persist_q <= 1'b0;
      end
    end
  end

  // R5: persistent mode only starts after a mask load
  assert_persist_set_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(persist_q) |-> $past(ld_mask));
  // R6: persistent mode only ends through the end-persist code
  assert_persist_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(persist_q) |-> $past(end_persist));
  // R7: color changes only through a color load
  assert_color_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_color) |-> $stable(color_q));
  // R5: mask register changes only through a mask load
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_mask) |-> $stable(mask_q));
endmodule

// File: rtl/bwr_slot.sv
module bwr_slot #(
  parameter int DATA_W = 16,
  parameter int COLS   = 8,
  parameter int LANE_W = 8,
  parameter int IDX    = 0
) (
  input  logic                     blk,
  input  logic                     word_hit,
  input  logic [DATA_W-1:0]        col_mask,
  input  logic [DATA_W-1:0]        io_mask,
  input  logic [DATA_W/LANE_W-1:0] lane_en,
  input  logic [DATA_W-1:0]        word_data,
  input  logic [DATA_W-1:0]        color,
  output logic [DATA_W-1:0]        data,
  output logic [DATA_W-1:0]        en
);
  always_comb begin
    data = blk ? color : (word_hit ? word_data : '0);
    for (int b = 0; b < DATA_W; b++) begin
      if (blk)
        en[b] = col_mask[(b / LANE_W) * COLS + IDX] & io_mask[b] & lane_en[b / LANE_W];
      else if (word_hit)
        en[b] = io_mask[b] & lane_en[b / LANE_W];
      else
        en[b] = 1'b0;
    end
  end
endmodule

// File: rtl/blkwr_datapath.sv
module blkwr_datapath #(
  parameter int DATA_W = 16,
  parameter int COLS   = 8,
  parameter int ADDR_W = 9,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic [DATA_W-1:0]          row_dq,
  input  logic [DATA_W-1:0]          col_dq,
  input  logic [ADDR_W-1:0]          col_addr,
  input  logic [DATA_W/LANE_W-1:0]   lane_en,
  output logic                       wr_valid,
  output logic [ADDR_W-1:0]          wr_col_base,
  output logic [DATA_W*COLS-1:0]     wr_data,
  output logic [DATA_W*COLS-1:0]     wr_bit_en
);
  import bwr_pkg::*;

  localparam int LANES = DATA_W / LANE_W;
  localparam int SEL_W = $clog2(COLS);
  localparam int FLAT  = DATA_W * COLS;

  op_e op;
  logic is_word, is_block, is_masked, is_write;
  logic ld_mask, ld_color, end_persist;
  logic [DATA_W-1:0] color_q, mask_q, io_mask;
  logic persist_q;
  logic [FLAT-1:0] grp_data, grp_en;
  logic [ADDR_W-1:0] base_c;

  always_comb begin
    op          = op_valid ? op_e'(op_code) : OP_IDLE;
    is_word     = (op == OP_WORD) || (op == OP_WORD_MSK);
    is_block    = (op == OP_BLOCK) || (op == OP_BLOCK_MSK);
    is_masked   = (op == OP_WORD_MSK) || (op == OP_BLOCK_MSK);
    is_write    = is_word || is_block;
    ld_mask     = (op == OP_LD_MASK);
    ld_color    = (op == OP_LD_COLOR);
    end_persist = (op == OP_END_PERSIST);
    io_mask     = is_masked ? (persist_q ? mask_q : row_dq) : '1;
    base_c      = {col_addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
  end

  bwr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ld_mask(ld_mask), .ld_color(ld_color),
    .end_persist(end_persist), .din(col_dq),
    .color_q(color_q), .mask_q(mask_q), .persist_q(persist_q)
  );

  for (genvar i = 0; i < COLS; i++) begin : g_slot
    logic hit;
    assign hit = is_word && (col_addr[SEL_W-1:0] == SEL_W'(i));
    bwr_slot #(.DATA_W(DATA_W), .COLS(COLS), .LANE_W(LANE_W), .IDX(i)) u_slot (
      .blk(is_block), .word_hit(hit), .col_mask(col_dq), .io_mask(io_mask),
      .lane_en(lane_en), .word_data(col_dq), .color(color_q),
      .data(grp_data[i*DATA_W +: DATA_W]), .en(grp_en[i*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid    <= 1'b0;
      wr_col_base <= '0;
      wr_data     <= '0;
      wr_bit_en   <= '0;
    end else begin
      wr_valid    <= is_write;
      wr_col_base <= is_write ? base_c : '0;
      wr_data     <= grp_data;
      wr_bit_en   <= grp_en;
    end
  end

  // R2: no enables without a write
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> (wr_bit_en == '0));
  // R2: a write code yields a write one clock later
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    is_write |=> wr_valid);
  // R8: the group base is always aligned
  assert_base_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_col_base[SEL_W-1:0] == '0));
  // R7: every block-write slot carries the stored color
  assert_block_color_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && $past(is_block)) |-> (wr_data == {COLS{color_q}}));
  // R3: a word write enables at most one slot's worth of bits
  assert_word_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && $past(is_word)) |-> ($countones(wr_bit_en) <= DATA_W));
  // R10: an unmasked word write with both lanes set enables a full column
  assert_unmasked_full_R10: assert property (@(posedge clk) disable iff (rst)
    $past(op == OP_WORD && lane_en == '1) |-> ($countones(wr_bit_en) == DATA_W));
endmodule

// File: tb/blkwr_datapath_test.sv
module blkwr_datapath_test;
  localparam int W = 16, C = 8, AW = 9, FLAT = W * C;

  logic clk = 1'b0, rst = 1'b1, op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [W-1:0] row_dq = '0, col_dq = '0;
  logic [AW-1:0] col_addr = '0;
  logic [1:0] lane_en = '0;
  logic wr_valid;
  logic [AW-1:0] wr_col_base;
  logic [FLAT-1:0] wr_data, wr_bit_en;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_color = '0, m_mask = '0;
  logic m_pers = 1'b0;
  logic [W-1:0] mem_ref [512];
  logic [W-1:0] mem_dut [512];

  always #4 clk = ~clk;

  blkwr_datapath uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .row_dq(row_dq), .col_dq(col_dq), .col_addr(col_addr), .lane_en(lane_en),
    .wr_valid(wr_valid), .wr_col_base(wr_col_base), .wr_data(wr_data),
    .wr_bit_en(wr_bit_en)
  );

  task automatic check(input string req, input logic [FLAT-1:0] got, input logic [FLAT-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_io(input logic [2:0] op, input logic [W-1:0] row);
    if (op == 3'd2 || op == 3'd4) return m_pers ? m_mask : row;
    return '1;
  endfunction

  function automatic logic [FLAT-1:0] exp_en(input logic [2:0] op, input logic [W-1:0] row,
      input logic [W-1:0] col, input logic [AW-1:0] addr, input logic [1:0] ln);
    logic [FLAT-1:0] r = '0;
    logic [W-1:0] io = exp_io(op, row);
    for (int c = 0; c < C; c++)
      for (int b = 0; b < W; b++) begin
        if (op == 3'd3 || op == 3'd4)
          r[c*W+b] = col[(b/8)*8+c] & io[b] & ln[b/8];
        else if ((op == 3'd1 || op == 3'd2) && addr[2:0] == 3'(c))
          r[c*W+b] = io[b] & ln[b/8];
      end
    return r;
  endfunction

  function automatic logic [FLAT-1:0] exp_data(input logic [2:0] op, input logic [W-1:0] col,
      input logic [AW-1:0] addr);
    logic [FLAT-1:0] r = '0;
    for (int c = 0; c < C; c++) begin
      if (op == 3'd3 || op == 3'd4) r[c*W +: W] = m_color;
      else if ((op == 3'd1 || op == 3'd2) && addr[2:0] == 3'(c)) r[c*W +: W] = col;
    end
    return r;
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [W-1:0] row, input logic [W-1:0] col,
      input logic [AW-1:0] addr, input logic [1:0] ln, input string req);
    logic wr = (op >= 3'd1 && op <= 3'd4);
    logic [FLAT-1:0] ed = exp_data(op, col, addr);
    logic [FLAT-1:0] ee = exp_en(op, row, col, addr, ln);
    logic [AW-1:0] eb = wr ? {addr[AW-1:3], 3'b000} : '0;
    op_valid = 1'b1; op_code = op; row_dq = row; col_dq = col; col_addr = addr; lane_en = ln;
    @(posedge clk); @(negedge clk);
    check({req, " valid"}, FLAT'(wr_valid), FLAT'(wr));
    check({req, " base"}, FLAT'(wr_col_base), FLAT'(eb));
    check({req, " data"}, wr_data, ed);
    check({req, " enable"}, wr_bit_en, ee);
    for (int c = 0; c < C; c++) begin
      mem_ref[eb + c] = (mem_ref[eb + c] & ~ee[c*W +: W]) | (ed[c*W +: W] & ee[c*W +: W]);
      mem_dut[wr_col_base + c] = (mem_dut[wr_col_base + c] & ~wr_bit_en[c*W +: W])
                               | (wr_data[c*W +: W] & wr_bit_en[c*W +: W]);
    end
    if (op == 3'd5) begin m_mask = col; m_pers = 1'b1; end
    if (op == 3'd6) m_color = col;
    if (op == 3'd7) m_pers = 1'b0;
    op_valid = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) begin mem_ref[i] = '0; mem_dut[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", FLAT'(wr_valid), '0);
    check("R1 reset enable", wr_bit_en, '0);
    check("R1 reset data", wr_data, '0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 first cycle enable", wr_bit_en, '0);
    // R4 with persistent mode off after reset (R1)
    do_op(3'd2, 16'h0F0F, 16'hABCD, 9'd13, 2'b11, "R4 masked word");
    do_op(3'd1, 16'h0000, 16'h1234, 9'd7, 2'b11, "R3 word slot 7");
    do_op(3'd1, 16'h0000, 16'h5678, 9'd200, 2'b01, "R9 low lane only");
    do_op(3'd0, 16'hFFFF, 16'hFFFF, 9'd5, 2'b11, "R2 idle code");
    do_op(3'd6, 16'h0000, 16'hC0DE, 9'd0, 2'b11, "R7 load color");
    do_op(3'd3, 16'h0000, 16'hFFFF, 9'd77, 2'b11, "R8 block low bits ignored");
    do_op(3'd4, 16'h00FF, 16'h81A5, 9'd300, 2'b11, "R9 masked block");
    do_op(3'd5, 16'h0000, 16'h3C3C, 9'd0, 2'b11, "R5 load mask");
    do_op(3'd2, 16'hFFFF, 16'h9999, 9'd41, 2'b11, "R5 row bus ignored");
    do_op(3'd4, 16'h0000, 16'hFFFF, 9'd64, 2'b10, "R5 persistent block");
    do_op(3'd3, 16'h0000, 16'h0F0F, 9'd128, 2'b11, "R10 unmasked block in persist");
    do_op(3'd1, 16'h0000, 16'h4242, 9'd129, 2'b11, "R10 unmasked word in persist");
    do_op(3'd7, 16'h0000, 16'h0000, 9'd0, 2'b11, "R6 end persist");
    do_op(3'd2, 16'hF00F, 16'h7777, 9'd42, 2'b11, "R6 row bus again");
    for (int i = 0; i < 400; i++)
      do_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom), 9'($urandom),
            2'($urandom), "R9 random");
    for (int i = 0; i < 512; i++)
      check("R9 array", FLAT'(mem_dut[i]), FLAT'(mem_ref[i]));
    report();
  end
endmodule